// File: doc/BRIEF.md
# Keyed Configuration Port with Device Banking

This block puts a large configuration space behind a two-byte I/O window. A host reaches it with byte reads and writes. The index port sits at the window base, and the data port sits one byte above it. The host writes a register number to the index port and then reads or writes that register through the data port. One select bit tells the block which of the two ports an access targets, so the bus decoding of the window base stays outside the block.

The window stays closed after reset. It opens only when the host writes the unlock key 0x87 to the index port on two index writes in a row. It closes again when the host writes 0xAA to the index port.

The space has two parts:
- Offsets below 0x30 are shared by all devices. This part holds:
  - a device-select register at 0x07;
  - a read-only 16-bit identifier at 0x20 (high byte) and 0x21 (low byte).
- Offsets from 0x30 upward form a separate bank for each logical device. The device-select register chooses which bank the host sees. Offset 0x30 of each bank is that device's enable register.

Top module: `cfg_keyport`

## Requirements
- R1: The window opens only after two consecutive index-port writes of 0x87. After a single 0x87, data-port reads still return 0xFF.
- R2: While the block is locked, any index-port write other than 0x87 restarts the key sequence. The sequence 0x87, 0x55, 0x87 leaves the block locked, and one further 0x87 then opens it.
- R3: While the block is open, an index-port write of 0xAA locks it again. This write does not change the stored index, and data-port reads then return 0xFF.
- R4: While the block is locked, reads of either port return 0xFF, and data-port writes do not change any register.
- R5: While the block is open, every index-port write other than 0xAA stores its byte as the index, including 0x87. An index-port read returns the stored index.
- R6: Offset 0x07 holds the selected device number as a full byte. It resets to 0x00 and reads back the value last written.
- R7: Offsets 0x30 to 0x30+BANK_DEPTH-1 are stored separately for each device below NUM_DEV. With defaults, offset 0x30 (the enable register) and offset 0x3F of device 0 and of device 3 keep independent values.
- R8: Offsets below 0x30 are shared. A value written to 0x2C with device 0 selected reads back unchanged with device 3 selected.
- R9: Offset 0x20 reads CHIP_ID[15:8] (0xA2 by default). Offset 0x21 reads CHIP_ID[7:0] (0x35 by default). Writes to either offset have no effect.
- R10: Banked offsets at or above 0x30+BANK_DEPTH read 0x00 and ignore writes, and so does every banked offset while the selected device is NUM_DEV or higher.
- R11: After reset the block is locked, the index is 0x00, and every writable register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | Port select: 0 is the index port, 1 is the data port |
| wr_i | input | 1 | Byte write strobe, one cycle per write |
| rd_i | input | 1 | Byte read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data. It follows the current state in the same cycle while rd_i is high and is 0x00 otherwise |

## Verification
The assertions take for granted that wr_i and rd_i are never high in the same cycle. They also take each cycle with wr_i high as exactly one byte write, so a write strobe held across several edges counts as repeated writes and would advance the key sequence. The stimulus respects both points: every access raises exactly one strobe for exactly one clock edge, changes all inputs half a cycle away from the sampling edge, and drops the strobe before the next access.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
  localparam logic [7:0] KEY_UNLOCK  = 8'h87;
  localparam logic [7:0] KEY_LOCK    = 8'hAA;
  localparam logic [7:0] REG_DEV_SEL = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] BANK_BASE   = 8'h30;
  localparam logic [7:0] LOCKED_BYTE = 8'hFF;
  localparam int unsigned GLB_REGS   = 48;  // offsets below BANK_BASE

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_ARMED,
    KS_OPEN
  } key_state_e;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_keyport_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KS_IDLE:  state_d = (wdata_i == KEY_UNLOCK) ? KS_ARMED : KS_IDLE;
        KS_ARMED: state_d = (wdata_i == KEY_UNLOCK) ? KS_OPEN  : KS_IDLE;
        KS_OPEN:  state_d = (wdata_i == KEY_LOCK)   ? KS_IDLE  : KS_OPEN;
        default:  state_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;

  assign open_o = (state_q == KS_OPEN);

  assert_two_keys_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !$past(open_o)) |->
      ($past(idx_wr_i) && $past(wdata_i) == KEY_UNLOCK && $past(state_q) == KS_ARMED));

  assert_key_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_ARMED && idx_wr_i && wdata_i != KEY_UNLOCK) |=> (state_q == KS_IDLE));

  assert_relock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == KEY_LOCK) |=> !open_o);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_keyport_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'hA235
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] dev_sel_o
);
  logic [GLB_REGS-1:0][7:0] mem_q;

  for (genvar g = 0; g < GLB_REGS; g++) begin : g_reg
    if (g == int'(REG_ID_HI) || g == int'(REG_ID_LO)) begin : g_ro
      assign mem_q[g] = 8'h00;  // identifier is read through the mux
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                        mem_q[g] <= 8'h00;
        else if (we_i && idx_i == 8'(g))    mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    if (idx_i == REG_ID_HI)      rdata_o = CHIP_ID[15:8];
    else if (idx_i == REG_ID_LO) rdata_o = CHIP_ID[7:0];
    else if (idx_i < BANK_BASE)  rdata_o = mem_q[idx_i[5:0]];
    else                         rdata_o = 8'h00;
  end

  assign dev_sel_o = mem_q[REG_DEV_SEL[5:0]];

  assert_dev_sel_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && idx_i == REG_DEV_SEL) |=> $stable(dev_sel_o));
endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned OFF_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [DEPTH-1:0][7:0] mem_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                          mem_q[e] <= 8'h00;
      else if (we_i && off_i == OFF_W'(e))  mem_q[e] <= wdata_i;
  end

  assign rdata_o = mem_q[off_i];

  assert_bank_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfg_keyport_pkg::*;
#(
  parameter int unsigned NUM_DEV    = 8,   // 2..255
  parameter int unsigned BANK_DEPTH = 16,  // 2..208
  parameter logic [15:0] CHIP_ID    = 16'hA235
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       port_sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int unsigned DEV_W = $clog2(NUM_DEV);
  localparam int unsigned OFF_W = $clog2(BANK_DEPTH);
  localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);
  localparam logic [7:0] DEPTH_B   = 8'(BANK_DEPTH);

  logic       open;
  logic [7:0] index_q;
  logic       idx_wr, data_wr;
  logic [7:0] dev_sel, glb_rdata, bank_off;
  logic       in_bank, bank_hit;
  logic [7:0] bank_rdata [NUM_DEV];
  logic [7:0] space_rdata;

  assign idx_wr  = wr_i && !port_sel_i;
  assign data_wr = wr_i && port_sel_i && open;

  cfg_unlock_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr),
    .wdata_i  (wdata_i),
    .open_o   (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                     index_q <= 8'h00;
    else if (idx_wr && open && wdata_i != KEY_LOCK)  index_q <= wdata_i;

  cfg_global_regs #(.CHIP_ID(CHIP_ID)) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (data_wr && !in_bank),
    .idx_i     (index_q),
    .wdata_i   (wdata_i),
    .rdata_o   (glb_rdata),
    .dev_sel_o (dev_sel)
  );

  assign in_bank  = (index_q >= BANK_BASE);
  assign bank_off = index_q - BANK_BASE;
  assign bank_hit = in_bank && (bank_off < DEPTH_B) && (dev_sel < NUM_DEV_B);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    cfg_bank_regs #(.DEPTH(BANK_DEPTH)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (data_wr && bank_hit && dev_sel == 8'(d)),
      .off_i   (bank_off[OFF_W-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (bank_rdata[d])
    );
  end

  always_comb begin
    if (!in_bank)      space_rdata = glb_rdata;
    else if (bank_hit) space_rdata = bank_rdata[dev_sel[DEV_W-1:0]];
    else               space_rdata = 8'h00;
  end

  always_comb begin
    if (!rd_i)            rdata_o = 8'h00;
    else if (!open)       rdata_o = LOCKED_BYTE;
    else if (!port_sel_i) rdata_o = index_q;
    else                  rdata_o = space_rdata;
  end

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));

  assert_locked_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !open) |-> (rdata_o == LOCKED_BYTE));

  assert_locked_index_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && wr_i) |=> $stable(index_q));

  assert_id_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && open && port_sel_i && index_q == REG_ID_HI) |-> (rdata_o == CHIP_ID[15:8]));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && open && port_sel_i && in_bank && dev_sel >= NUM_DEV_B) |-> (rdata_o == 8'h00));
endmodule

// File: tb/cfg_keyport_tb_top.sv
module cfg_keyport_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_sel = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  cfg_keyport dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .port_sel_i (port_sel),
    .wr_i       (wr),
    .rd_i       (rd),
    .wdata_i    (wdata),
    .rdata_o    (rdata)
  );

  typedef struct packed {
    logic       is_wr;
    logic       port;
    logic [7:0] val;
    logic [7:0] exp_v;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h00, 8'hFF, 4'd4},  // R4 locked read
    '{1'b1, 1'b0, 8'h87, 8'h00, 4'd1},
    '{1'b0, 1'b1, 8'h00, 8'hFF, 4'd1},  // R1 one key only
    '{1'b1, 1'b0, 8'h55, 8'h00, 4'd2},
    '{1'b1, 1'b0, 8'h87, 8'h00, 4'd2},
    '{1'b0, 1'b1, 8'h00, 8'hFF, 4'd2},  // R2 sequence broken
    '{1'b1, 1'b0, 8'h87, 8'h00, 4'd2},  // second key: open
    '{1'b1, 1'b0, 8'h20, 8'h00, 4'd9},
    '{1'b0, 1'b1, 8'h00, 8'hA2, 4'd9},  // R9 id high
    '{1'b1, 1'b0, 8'h21, 8'h00, 4'd9},
    '{1'b0, 1'b1, 8'h00, 8'h35, 4'd9},  // R9 id low
    '{1'b0, 1'b0, 8'h00, 8'h21, 4'd5},  // R5 index readback
    '{1'b1, 1'b1, 8'h5A, 8'h00, 4'd9},
    '{1'b0, 1'b1, 8'h00, 8'h35, 4'd9},  // R9 write ignored
    '{1'b1, 1'b0, 8'h87, 8'h00, 4'd5},
    '{1'b0, 1'b0, 8'h00, 8'h87, 4'd5},  // R5 key byte is plain index
    '{1'b1, 1'b0, 8'h07, 8'h00, 4'd6},
    '{1'b0, 1'b1, 8'h00, 8'h00, 4'd6},  // R6 reset device
    '{1'b1, 1'b0, 8'h30, 8'h00, 4'd7},
    '{1'b1, 1'b1, 8'h01, 8'h00, 4'd7},
    '{1'b0, 1'b1, 8'h00, 8'h01, 4'd7},  // R7 dev0 enable
    '{1'b1, 1'b0, 8'h07, 8'h00, 4'd6},
    '{1'b1, 1'b1, 8'h03, 8'h00, 4'd6},
    '{1'b0, 1'b1, 8'h00, 8'h03, 4'd6},  // R6 readback
    '{1'b1, 1'b0, 8'h30, 8'h00, 4'd7},
    '{1'b0, 1'b1, 8'h00, 8'h00, 4'd7},  // R7 dev3 separate
    '{1'b1, 1'b1, 8'hC4, 8'h00, 4'd7},
    '{1'b0, 1'b1, 8'h00, 8'hC4, 4'd7},
    '{1'b1, 1'b0, 8'h07, 8'h00, 4'd7},
    '{1'b1, 1'b1, 8'h00, 8'h00, 4'd7},
    '{1'b1, 1'b0, 8'h30, 8'h00, 4'd7},
    '{1'b0, 1'b1, 8'h00, 8'h01, 4'd7},  // R7 dev0 kept
    '{1'b1, 1'b0, 8'h2C, 8'h00, 4'd8},
    '{1'b1, 1'b1, 8'h6B, 8'h00, 4'd8},
    '{1'b1, 1'b0, 8'h07, 8'h00, 4'd8},
    '{1'b1, 1'b1, 8'h03, 8'h00, 4'd8},
    '{1'b1, 1'b0, 8'h2C, 8'h00, 4'd8},
    '{1'b0, 1'b1, 8'h00, 8'h6B, 4'd8},  // R8 shared
    '{1'b1, 1'b0, 8'hAA, 8'h00, 4'd3},
    '{1'b0, 1'b1, 8'h00, 8'hFF, 4'd3},  // R3 relocked
    '{1'b0, 1'b0, 8'h00, 8'hFF, 4'd4},  // R4 index port locked
    '{1'b1, 1'b1, 8'h77, 8'h00, 4'd4}   // R4 write while locked
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp_v, input string tag);
    n_checks++;
    if (got !== exp_v) begin
      n_fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp_v);
    end
  endtask

  task automatic wr_port(input logic p, input logic [7:0] v);
    @(negedge clk);
    port_sel = p; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic p, input logic [7:0] exp_v, input string tag);
    @(negedge clk);
    port_sel = p; rd = 1'b1;
    #1 check(rdata, exp_v, tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) wr_port(VECS[i].port, VECS[i].val);
      else rd_port(VECS[i].port, VECS[i].exp_v, $sformatf("R%0d vec %0d", VECS[i].req, i));
    end
    // R4: locked write must not have reached 0x2C
    wr_port(1'b0, 8'h87); wr_port(1'b0, 8'h87);
    rd_port(1'b0, 8'h2C, "R3 index kept over relock");
    rd_port(1'b1, 8'h6B, "R4 locked write ignored");
    // R10: device out of range
    wr_port(1'b0, 8'h07); wr_port(1'b1, 8'h0F);
    wr_port(1'b0, 8'h30); wr_port(1'b1, 8'h99);
    rd_port(1'b1, 8'h00, "R10 device beyond range");
    // R10: offset beyond depth, then R7 last banked offset
    wr_port(1'b0, 8'h07); wr_port(1'b1, 8'h01);
    wr_port(1'b0, 8'h40); wr_port(1'b1, 8'h99);
    rd_port(1'b1, 8'h00, "R10 offset beyond depth");
    wr_port(1'b0, 8'h3F); wr_port(1'b1, 8'h5E);
    rd_port(1'b1, 8'h5E, "R7 last banked offset");
    wr_port(1'b0, 8'h07); wr_port(1'b1, 8'h03);
    wr_port(1'b0, 8'h3F);
    rd_port(1'b1, 8'h00, "R7 last offset separate per device");
    // R11: reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_port(1'b1, 8'hFF, "R11 locked after reset");
    wr_port(1'b0, 8'h87); wr_port(1'b0, 8'h87);
    rd_port(1'b0, 8'h00, "R11 index reset");
    wr_port(1'b0, 8'h07);
    rd_port(1'b1, 8'h00, "R11 device select reset");
    wr_port(1'b0, 8'h2C);
    rd_port(1'b1, 8'h00, "R11 global reset");
    wr_port(1'b0, 8'h30);
    rd_port(1'b1, 8'h00, "R11 bank reset");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule